// File: doc/BRIEF.md
# Dual-Downstream Bus Switch Control Core

This block holds the channel-select state for a switch that links an upstream serial bus to two downstream segments. An upstream target front end gives the block a strobe and data byte for each decoded control write. The block keeps the written selection as pending state. That state reaches the two connect enables only when the front end reports a bus STOP. Because of this, the downstream clock and data lines are joined only while the bus is idle.

The block also watches two active-low interrupt lines, one for each downstream segment. Each line passes through a two-stage synchronizer. While either synchronized line is asserted, the block drives an open-drain interrupt output low. A read strobe loads a status byte that holds the active enables in bits 1:0 and the live interrupt levels in bits 5:4. The block keeps no latched interrupt state. An interrupt is cleared at the device that raised it.

Top module: `bus_switch_ctrl`

## Requirements
- R1: After reset, en_o is 2'b00, rd_data_o is 8'h00, and int_oe_o is 0.
- R2: A write strobe stores wr_data_i[1:0] as pending state: bit 0 selects channel 0 and bit 1 selects channel 1. Bits 7:2 of the written byte have no effect on channel selection.
- R3: A write does not change en_o. en_o takes the pending value on the clock edge where stop_i is sampled high. If wr_stb_i and stop_i are high in the same cycle, the byte written in that cycle is the one applied.
- R4: en_o = 2'b11 is a legal state, so both channels may be connected at once.
- R5: When several writes come before a STOP, the STOP applies only the last written value.
- R6: On the clock edge where rd_stb_i is high, rd_data_o loads {2'b00, s1, s0, 2'b00, en_o}. Here s0 and s1 are the synchronized asserted states of int_n_i[0] and int_n_i[1], and en_o is the value before that edge. rd_data_o holds its value between reads.
- R7: The interrupt status bits follow the inputs whether or not the channel is enabled. They are never latched.
- R8: int_oe_o is 1 (drive low) exactly when either synchronized interrupt is asserted. A change on int_n_i reaches int_oe_o after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | Control-byte write strobe |
| wr_data_i | input | 8 | Written control byte |
| stop_i | input | 1 | Bus STOP detected pulse |
| rd_stb_i | input | 1 | Load the readback byte |
| int_n_i | input | 2 | Downstream interrupt inputs, active low |
| en_o | output | 2 | Channel connect enables |
| rd_data_o | output | 8 | Readback byte |
| int_oe_o | output | 1 | Open-drain interrupt output, 1 = drive low |

## Verification
The assertions assume that the strobes and stop_i are synchronous single-cycle-qualified inputs. They also assume that int_n_i may change at any time, because it is synchronized inside the block. The stimulus changes every input half a period away from the active edge. It mixes random write and STOP pulses, including same-cycle collisions and back-to-back writes. Interrupt levels are toggled randomly while channels are enabled and while they are disabled.

// File: rtl/bus_switch_pkg.sv
package bus_switch_pkg;
  parameter int unsigned NUM_CH  = 2;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned SYNC_STAGES = 2;
  parameter int unsigned INT_LSB = 4;
  typedef logic [NUM_CH-1:0] ch_vec_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bus_switch_sync.sv
module bus_switch_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to released (high) level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bus_switch_sel.sv
module bus_switch_sel
  import bus_switch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_stb_i,
  input  ch_vec_t wr_sel_i,
  input  logic    stop_i,
  output ch_vec_t en_o
);
  ch_vec_t pend_q, en_q, pend_nxt;

  // a write coinciding with STOP is applied by that STOP
  assign pend_nxt = wr_stb_i ? wr_sel_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (stop_i) en_q <= pend_nxt;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/bus_switch_ctrl.sv
module bus_switch_ctrl
  import bus_switch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stb_i,
  input  logic [7:0] wr_data_i,
  input  logic       stop_i,
  input  logic       rd_stb_i,
  input  logic [1:0] int_n_i,
  output logic [1:0] en_o,
  output logic [7:0] rd_data_o,
  output logic       int_oe_o
);
  ch_vec_t int_n_sync, int_act, en_w;
  byte_t   rd_q, rd_nxt;

  bus_switch_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (int_n_i),
    .q_o   (int_n_sync)
  );

  assign int_act = ~int_n_sync;

  bus_switch_sel u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_stb_i(wr_stb_i),
    .wr_sel_i(wr_data_i[NUM_CH-1:0]),
    .stop_i  (stop_i),
    .en_o    (en_w)
  );

  always_comb begin
    rd_nxt = '0;
    rd_nxt[NUM_CH-1:0] = en_w;
    rd_nxt[INT_LSB +: NUM_CH] = int_act;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (rd_stb_i) rd_q <= rd_nxt;
  end

  assign en_o      = en_w;
  assign rd_data_o = rd_q;
  assign int_oe_o  = |int_act;
endmodule

// File: rtl/bus_switch_ctrl_chk.sv
module bus_switch_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_stb_i,
  input logic [7:0] wr_data_i,
  input logic       stop_i,
  input logic       rd_stb_i,
  input logic [1:0] int_n_i,
  input logic [1:0] en_o,
  input logic [7:0] rd_data_o,
  input logic       int_oe_o
);
  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(en_o));
  // R3
  en_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wr_stb_i) |=> en_o == $past(wr_data_i[1:0]));
  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb_i |=> $stable(rd_data_o));
  // R6
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00 && rd_data_o[3:2] == 2'b00);
  // R6
  rd_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> rd_data_o[1:0] == $past(en_o));
  // R8
  int_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&int_n_i && $past(&int_n_i)) |=> !int_oe_o);
  // R8
  int_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&int_n_i) && $past(!(&int_n_i)) && $past(int_n_i) == int_n_i) |=> int_oe_o);
endmodule

bind bus_switch_ctrl bus_switch_ctrl_chk u_chk (.*);

// File: tb/bus_switch_ctrl_tb_top.sv
module bus_switch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       wr_stb_i = 0;
  logic [7:0] wr_data_i = 0;
  logic       stop_i = 0;
  logic       rd_stb_i = 0;
  logic [1:0] int_n_i = 2'b11;
  logic [1:0] en_o;
  logic [7:0] rd_data_o;
  logic       int_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bus_switch_ctrl dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  int m_pend, m_en, m_rd;
  int int_hist[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model update at each edge; inputs are stable around edges
  always @(posedge clk_i) begin
    if (rst_ni) begin
      int act;
      act = (int_hist[1] ^ 3);
      if (rd_stb_i) m_rd = (act << 4) | m_en;
      if (wr_stb_i) m_pend = wr_data_i & 3;
      if (stop_i) m_en = m_pend;
      int_hist.push_front(int_n_i);
      void'(int_hist.pop_back());
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R3 en", en_o, m_en);
      chk("R6 rd", rd_data_o, m_rd);
      chk("R8 int", int_oe_o, (int_hist[1] != 3) ? 1 : 0);
    end
  end

  task automatic step(bit w, int d, bit s, bit r, int in);
    wr_stb_i = w; wr_data_i = d[7:0]; stop_i = s; rd_stb_i = r; int_n_i = in[1:0];
    @(negedge clk_i);
  endtask

  initial begin
    m_pend = 0; m_en = 0; m_rd = 0;
    int_hist = '{3, 3};
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    chk("R1 en", en_o, 0);
    chk("R1 rd", rd_data_o, 0);
    chk("R1 int", int_oe_o, 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    // R2 upper bits ignored, R3 no effect before STOP
    step(1, 8'hFD, 0, 0, 3);
    step(0, 0, 0, 0, 3);
    chk("R3 hold", en_o, 0);
    step(0, 0, 1, 0, 3);
    chk("R2 sel", en_o, 1);
    // R4 both channels
    step(1, 8'h03, 0, 0, 3);
    step(0, 0, 1, 0, 3);
    chk("R4 both", en_o, 3);
    // R5 last write wins
    step(1, 8'h01, 0, 0, 3);
    step(1, 8'h02, 0, 0, 3);
    step(0, 0, 1, 0, 3);
    chk("R5 last", en_o, 2);
    // R3 same-cycle write+stop
    step(1, 8'h01, 1, 0, 3);
    chk("R3 coll", en_o, 1);
    // R7 interrupt on disabled channel 1, read status
    step(1, 8'h00, 1, 0, 2'b01);
    step(0, 0, 0, 0, 2'b01);
    step(0, 0, 0, 0, 2'b01);
    chk("R8 drive", int_oe_o, 1);
    step(0, 0, 0, 1, 2'b01);
    chk("R7 rd", rd_data_o, 8'h20);
    // R7 released, not latched
    step(0, 0, 0, 0, 3);
    step(0, 0, 0, 0, 3);
    step(0, 0, 0, 1, 3);
    chk("R7 clr", rd_data_o, 8'h00);
    chk("R8 rel", int_oe_o, 0);
    // R6 mixed readback
    step(1, 8'h03, 1, 0, 2'b10);
    step(0, 0, 0, 0, 2'b10);
    step(0, 0, 0, 1, 2'b10);
    chk("R6 mix", rd_data_o, 8'h13);
    // random phase
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0,1) == 0, $urandom, $urandom_range(0,3) == 0,
           $urandom_range(0,2) == 0, $urandom_range(0,3));
    step(0, 0, 0, 0, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule